// File: doc/BRIEF.md
# Bitmask-Capturing Interrupt Controller

This block sits beside a small processor core and collects interrupt requests on 32 lines. Each line can be raised from a 32-bit external request vector. The three lowest lines can also be raised by sources inside the core. Requests are sticky: a single-cycle pulse is remembered in a pending set until it is serviced. A mask register selects which pending lines are allowed to interrupt the core. The block raises a request output when at least one unmasked line is pending and no handler is running.

When the core accepts the interrupt, the block loads a bank of four 32-bit handler registers. Slot 0 receives the return address supplied with the accept strobe. Slot 1 receives the bitmask of every unmasked pending line, so a single handler entry services all of them together. The block does no priority encoding. The captured lines are removed from the pending set and their end-of-interrupt outputs go high. Those outputs stay high until the core signals handler return. Slots 2 and 3 are scratch storage that is never initialised. The core reads and writes all four slots through a single-cycle port.

Top module: `irq_capture_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `active_o` is 0, `eoi_o` is all zeros, and the mask register holds all ones, so every line is masked.
- R2: A request bit seen high for one cycle, on `ext_req_i` or `int_req_i`, stays pending until an accepted interrupt captures it.
- R3: `int_req_i[k]` raises line k for k = 0, 1, 2, in the same way as `ext_req_i[k]`.
- R4: A pending line whose mask bit is 1 does not raise `irq_o`. It stays pending, and it raises `irq_o` once its mask bit is written to 0 through `mask_we_i`/`mask_wdata_i`.
- R5: `irq_o` is high exactly when no handler is active and at least one line is both pending and unmasked.
- R6: A `take_i` strobe in a cycle where `irq_o` is low is ignored. No handler starts, and slots 0 and 1 keep their values.
- R7: An accepted take (`take_i` with `irq_o` high) loads slot 0 with `take_pc_i` and slot 1 with the mask of pending unmasked lines, and clears those lines from the pending set. Both registers update at the clock edge of the accept.
- R8: From the cycle after an accepted take, `eoi_o` equals the captured mask and `active_o` is 1. `eoi_o` holds that value until `ret_i` is seen while active. From the cycle after that, `eoi_o` is 0 and `active_o` is 0.
- R9: While a handler is active, `irq_o` stays low. Requests arriving during the handler accumulate and raise `irq_o` after the return.
- R10: The handler register port reads and writes slots 0 to 3 selected by `sr_addr_i` (0 = return address, 1 = captured mask, 2 and 3 = scratch). The read is combinational and a write takes effect at the next clock edge.
- R11: A port write to slot 0 or 1 in the cycle of an accepted take is lost to the capture. A port write to slot 2 or 3 in that same cycle takes effect.
- R12: Lines that are pending but masked at the moment of an accepted take are not captured, and they remain pending afterwards.
- R13: `ret_i` while no handler is active has no effect on `active_o`, `eoi_o` or the pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_i | input | 32 | External request lines |
| int_req_i | input | 3 | Core-internal requests for lines 0..2 |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 32 | New mask value (1 = masked) |
| irq_o | output | 1 | Interrupt request to the core |
| take_i | input | 1 | Core accepts the interrupt |
| take_pc_i | input | 32 | Return address captured on accept |
| ret_i | input | 1 | Handler-return strobe |
| sr_we_i | input | 1 | Handler register write strobe |
| sr_addr_i | input | 2 | Handler register slot select |
| sr_wdata_i | input | 32 | Handler register write data |
| sr_rdata_o | output | 32 | Handler register read data |
| eoi_o | output | 32 | Per-line end-of-interrupt outputs |
| active_o | output | 1 | Handler in progress |

## Verification
The assertions check, on every cycle, the following rules:
- The request output stays low while a handler is active.
- The end-of-interrupt vector stays zero when idle and stays steady during a handler.
- An accept copies the pending unmasked set into that vector and removes those lines from the pending set.
- Pending bits never vanish except through capture.
- A return clears the handler state.

Only the bench scenarios can show the rest:
- the data path of the handler register slots;
- that a masked line survives a take and fires after unmasking;
- how a port write resolves against a simultaneous capture;
- that internal sources merge onto the low lines.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SLOT_RET   = 0;
    localparam int SLOT_LINES = 1;
    localparam int FIRST_SCRATCH = 2;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int NLINES = 32,
    parameter int NINT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] ext_req_i,
    input  logic [NINT-1:0]   int_req_i,
    input  logic              mask_we_i,
    input  logic [NLINES-1:0] mask_wdata_i,
    input  logic              active_i,
    input  logic              take_i,
    output logic              irq_o,
    output logic              take_ok_o,
    output logic [NLINES-1:0] grab_o,
    output logic [NLINES-1:0] pend_o,
    output logic [NLINES-1:0] mask_o
);
    localparam int PADW = NLINES - NINT;

    typedef struct packed {
        logic [NLINES-1:0] pend;
        logic [NLINES-1:0] mask;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic [NLINES-1:0] req_now;
    logic [NLINES-1:0] eligible;

    always_comb begin
        req_now   = ext_req_i | {{PADW{1'b0}}, int_req_i};
        eligible  = st_q.pend & ~st_q.mask;
        irq_o     = !active_i && (eligible != '0);
        take_ok_o = take_i && irq_o;
        grab_o    = take_ok_o ? eligible : '0;

        st_d      = st_q;
        st_d.pend = (st_q.pend & ~grab_o) | req_now;
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
endmodule

// File: rtl/irqc_handler.sv
module irqc_handler #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_ok_i,
    input  logic [NLINES-1:0] grab_i,
    input  logic              ret_i,
    output logic              active_o,
    output logic [NLINES-1:0] eoi_o
);
    typedef struct packed {
        logic              active;
        logic [NLINES-1:0] eoi;
    } hdl_state_t;

    hdl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_ok_i) begin
            st_d.active = 1'b1;
            st_d.eoi    = grab_i;
        end else if (st_q.active && ret_i) begin
            st_d.active = 1'b0;
            st_d.eoi    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign eoi_o    = st_q.eoi;
endmodule

// File: rtl/irqc_slots.sv
module irqc_slots #(
    parameter int XLEN   = 32,
    parameter int NLINES = 32,
    parameter int NSLOT  = 4,
    localparam int AW    = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_ok_i,
    input  logic [XLEN-1:0]   take_pc_i,
    input  logic [NLINES-1:0] grab_i,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [XLEN-1:0]   rdata_o
);
    import irqc_pkg::*;

    typedef struct packed {
        logic [XLEN-1:0]   ret_addr;
        logic [NLINES-1:0] lines;
    } cap_state_t;

    cap_state_t cap_d, cap_q;
    logic [XLEN-1:0] slot_val [NSLOT];

    always_comb begin
        cap_d = cap_q;
        if (take_ok_i) begin
            cap_d.ret_addr = take_pc_i;
            cap_d.lines    = grab_i;
        end else if (we_i && int'(addr_i) == SLOT_RET) begin
            cap_d.ret_addr = wdata_i;
        end else if (we_i && int'(addr_i) == SLOT_LINES) begin
            cap_d.lines = wdata_i[NLINES-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign slot_val[SLOT_RET]   = cap_q.ret_addr;
    assign slot_val[SLOT_LINES] = XLEN'(cap_q.lines);

    for (genvar g = FIRST_SCRATCH; g < NSLOT; g++) begin : g_scratch
        logic [XLEN-1:0] scr_d, scr_q;
        always_comb begin
            scr_d = scr_q;
            if (we_i && int'(addr_i) == g) begin
                scr_d = wdata_i;
            end
        end
        always_ff @(posedge clk) begin
            scr_q <= scr_d;
        end
        assign slot_val[g] = scr_q;
    end

    assign rdata_o = slot_val[addr_i];
endmodule

// File: rtl/irq_capture_ctrl.sv
module irq_capture_ctrl #(
    parameter int NLINES = 32,
    parameter int NINT   = 3,
    parameter int XLEN   = 32,
    parameter int NSLOT  = 4,
    localparam int AW    = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] ext_req_i,
    input  logic [NINT-1:0]   int_req_i,
    input  logic              mask_we_i,
    input  logic [NLINES-1:0] mask_wdata_i,
    output logic              irq_o,
    input  logic              take_i,
    input  logic [XLEN-1:0]   take_pc_i,
    input  logic              ret_i,
    input  logic              sr_we_i,
    input  logic [AW-1:0]     sr_addr_i,
    input  logic [XLEN-1:0]   sr_wdata_i,
    output logic [XLEN-1:0]   sr_rdata_o,
    output logic [NLINES-1:0] eoi_o,
    output logic              active_o
);
    logic              take_ok_w;
    logic [NLINES-1:0] grab_w;
    logic [NLINES-1:0] pend_w;
    logic [NLINES-1:0] mask_w;

    irqc_pending #(.NLINES(NLINES), .NINT(NINT)) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_req_i    (ext_req_i),
        .int_req_i    (int_req_i),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .active_i     (active_o),
        .take_i       (take_i),
        .irq_o        (irq_o),
        .take_ok_o    (take_ok_w),
        .grab_o       (grab_w),
        .pend_o       (pend_w),
        .mask_o       (mask_w)
    );

    irqc_handler #(.NLINES(NLINES)) u_hdl (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_ok_i (take_ok_w),
        .grab_i    (grab_w),
        .ret_i     (ret_i),
        .active_o  (active_o),
        .eoi_o     (eoi_o)
    );

    irqc_slots #(.XLEN(XLEN), .NLINES(NLINES), .NSLOT(NSLOT)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_ok_i (take_ok_w),
        .take_pc_i (take_pc_i),
        .grab_i    (grab_w),
        .we_i      (sr_we_i),
        .addr_i    (sr_addr_i),
        .wdata_i   (sr_wdata_i),
        .rdata_o   (sr_rdata_o)
    );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NLINES = 32,
    parameter int NINT   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] ext_req_i,
    input logic [NINT-1:0]   int_req_i,
    input logic              irq_o,
    input logic              take_i,
    input logic              ret_i,
    input logic [NLINES-1:0] eoi_o,
    input logic              active_o,
    input logic [NLINES-1:0] pend_w,
    input logic [NLINES-1:0] mask_w
);
    logic              acc;
    logic [NLINES-1:0] req_now;
    assign acc     = take_i && irq_o;
    assign req_now = ext_req_i | {{(NLINES-NINT){1'b0}}, int_req_i};

    AST_QUIET_IN_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> !irq_o); // R9
    AST_IDLE_NO_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (eoi_o == '0)); // R8
    AST_EOI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !ret_i) |=> $stable(eoi_o)); // R8
    AST_RET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && ret_i) |=> (!active_o && eoi_o == '0)); // R8
    AST_CAPTURE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (active_o && eoi_o == $past(pend_w & ~mask_w))); // R7
    AST_CAPTURE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ((pend_w & $past(pend_w & ~mask_w) & ~$past(req_now)) == '0)); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ((pend_w & $past(pend_w)) == $past(pend_w))); // R2
    AST_SPURIOUS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !irq_o && !active_o) |=> !active_o); // R6
endmodule

bind irq_capture_ctrl irqc_chk #(.NLINES(NLINES), .NINT(NINT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_req_i (ext_req_i),
    .int_req_i (int_req_i),
    .irq_o     (irq_o),
    .take_i    (take_i),
    .ret_i     (ret_i),
    .eoi_o     (eoi_o),
    .active_o  (active_o),
    .pend_w    (pend_w),
    .mask_w    (mask_w)
);

// File: tb/irq_capture_ctrl_test.sv
module irq_capture_ctrl_test;
    localparam int CLK_PERIOD = 10;

    typedef enum logic [1:0] {S_IRQ, S_EOI, S_ACT, S_RD} sel_t;
    typedef struct {
        string       tag;
        sel_t        sel;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ext_req = '0;
    logic [2:0]  int_req = '0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        irq;
    logic        take = 1'b0;
    logic [31:0] take_pc = '0;
    logic        ret = 1'b0;
    logic        sr_we = 1'b0;
    logic [1:0]  sr_addr = '0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] sr_rdata;
    logic [31:0] eoi;
    logic        active;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    item_t sb[$];

    irq_capture_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_req_i(ext_req), .int_req_i(int_req),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .irq_o(irq),
        .take_i(take), .take_pc_i(take_pc), .ret_i(ret),
        .sr_we_i(sr_we), .sr_addr_i(sr_addr), .sr_wdata_i(sr_wdata),
        .sr_rdata_o(sr_rdata), .eoi_o(eoi), .active_o(active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.sel)
                S_IRQ:   act = {31'b0, irq};
                S_EOI:   act = eoi;
                S_ACT:   act = {31'b0, active};
                default: act = sr_rdata;
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_val(string tag, sel_t s, logic [31:0] v);
        item_t it;
        it.tag = tag; it.sel = s; it.exp = v;
        sb.push_back(it);
    endtask

    task automatic rd(logic [1:0] a, logic [31:0] v, string tag);
        sr_addr = a;
        expect_val(tag, S_RD, v);
        step();
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] v);
        sr_we = 1'b1; sr_addr = a; sr_wdata = v;
        step();
        sr_we = 1'b0;
    endtask

    task automatic pulse_req(logic [31:0] e, logic [2:0] i);
        ext_req = e; int_req = i;
        step();
        ext_req = '0; int_req = '0;
    endtask

    task automatic set_mask(logic [31:0] m);
        mask_we = 1'b1; mask_wdata = m;
        step();
        mask_we = 1'b0;
    endtask

    task automatic do_take(logic [31:0] pc);
        take = 1'b1; take_pc = pc;
        step();
        take = 1'b0;
    endtask

    task automatic do_ret();
        ret = 1'b1;
        step();
        ret = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        expect_val("R1 irq after reset", S_IRQ, 32'd0);
        expect_val("R1 eoi after reset", S_EOI, 32'd0);
        expect_val("R1 active after reset", S_ACT, 32'd0);
        step();

        // R10: slot port round trip
        wr(2'd0, 32'hA000_0000);
        wr(2'd1, 32'h0000_00F0);
        wr(2'd2, 32'h1111_2222);
        wr(2'd3, 32'h3333_4444);
        rd(2'd0, 32'hA000_0000, "R10 slot0");
        rd(2'd1, 32'h0000_00F0, "R10 slot1");
        rd(2'd2, 32'h1111_2222, "R10 slot2");
        rd(2'd3, 32'h3333_4444, "R10 slot3");

        // R4: masked pending line is silent
        pulse_req(32'h0000_0020, 3'b000);
        repeat (3) step();
        expect_val("R4 masked line silent", S_IRQ, 32'd0);
        step();

        // R6: take with irq low ignored
        do_take(32'hBAD0_0000);
        expect_val("R6 no handler", S_ACT, 32'd0);
        expect_val("R6 no eoi", S_EOI, 32'd0);
        rd(2'd0, 32'hA000_0000, "R6 slot0 kept");
        rd(2'd1, 32'h0000_00F0, "R6 slot1 kept");

        // R3 internal line 1, R12 masked line 12, then unmask low byte
        pulse_req(32'h0000_1000, 3'b010);
        set_mask(32'hFFFF_FF00);
        expect_val("R4 R2 R5 unmasked pending raises irq", S_IRQ, 32'd1);
        step();

        do_take(32'h0000_1234);
        expect_val("R8 eoi = captured", S_EOI, 32'h0000_0022);
        expect_val("R8 active", S_ACT, 32'd1);
        expect_val("R9 irq low in handler", S_IRQ, 32'd0);
        rd(2'd0, 32'h0000_1234, "R7 return address");
        rd(2'd1, 32'h0000_0022, "R7 R3 captured mask");

        // R9: new request during handler accumulates
        pulse_req(32'h0000_0008, 3'b000);
        repeat (2) step();
        expect_val("R9 irq still low", S_IRQ, 32'd0);
        expect_val("R8 eoi held", S_EOI, 32'h0000_0022);
        step();

        do_ret();
        expect_val("R8 eoi cleared", S_EOI, 32'd0);
        expect_val("R8 inactive", S_ACT, 32'd0);
        expect_val("R9 accumulated request fires", S_IRQ, 32'd1);
        step();

        // R13: return while idle
        do_ret();
        expect_val("R13 still inactive", S_ACT, 32'd0);
        expect_val("R13 eoi unchanged", S_EOI, 32'd0);
        expect_val("R13 pending kept", S_IRQ, 32'd1);
        step();

        // R11: write to slot1 colliding with take loses
        sr_we = 1'b1; sr_addr = 2'd1; sr_wdata = 32'hDEAD_BEEF;
        do_take(32'h0000_2000);
        sr_we = 1'b0;
        rd(2'd1, 32'h0000_0008, "R11 slot1 write lost");
        rd(2'd0, 32'h0000_2000, "R7 second return address");
        do_ret();
        expect_val("R12 masked line 12 not yet eligible", S_IRQ, 32'd0);
        step();

        // R12 masked line survives; R3 internal line 2; R11 scratch write during take
        pulse_req(32'h0000_0000, 3'b100);
        set_mask(32'h0000_0000);
        expect_val("R12 line 12 still pending", S_IRQ, 32'd1);
        step();
        sr_we = 1'b1; sr_addr = 2'd2; sr_wdata = 32'h5555_6666;
        do_take(32'h0000_3000);
        sr_we = 1'b0;
        rd(2'd1, 32'h0000_1004, "R12 R3 captured mask");
        rd(2'd2, 32'h5555_6666, "R11 scratch write during take");
        expect_val("R8 eoi second entry", S_EOI, 32'h0000_1004);
        step();
        do_ret();
        expect_val("R5 nothing pending", S_IRQ, 32'd0);
        step();
        step();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule